// File: doc/BRIEF.md
# SPI Message Engine with Write-Only Prepend

This block is a single-master serial peripheral interface controller that runs one complete message per start command. Software loads the outgoing bytes into a transmit buffer, programs the message length, the message kind, an optional prepend length, the target select line and the serial clock setting, and then issues a start. The engine holds one select line low for the whole message and shifts the bytes out most significant bit first. It stores received bytes into a receive buffer, then releases the select line, sets a pending done flag and counts the captured bytes.

The prepend phase sends up to fifteen leading bytes as write-only traffic before the main phase. With it, a command byte sequence followed by a read of the reply fits inside a single select window. The main phase then runs full duplex, receive-only or transmit-only, as the message kind selects.

The register and buffer space is reached over a simple byte-wide write strobe with a combinational read port. Addresses with the upper two bits `00` hold eight control registers, `01` holds the transmit buffer and `10` holds the receive buffer.

Top module: `spi_msg_engine`

## Requirements
- R1: After reset every control register reads zero, all select lines are high, the serial clock is low, the data output is low and the interrupt output is low.
- R2: Writing the command register (address 2) with bit 7 set while idle starts a message that targets the select line numbered by bits [6:4]. Exactly that line goes low, and no line is low while the engine is idle. The serial clock rests at its idle level for one half period after the line falls. The line rises on the same clock edge that ends the last bit.
- R3: Clock code n in bits [2:0] of address 3 gives a serial half period of 2^n system cycles, and code 7 acts as code 6. A message of T bytes keeps the select line low for exactly (16*T+1)*2^n system cycles.
- R4: Bits leave most significant first. Transmit buffer entry k is sent as message byte k, with the prepend bytes at entries 0 to P-1 and the main bytes after them. The clock idles at the level in bit 3 of address 3. With bit 4 clear the input is sampled on the leading edge of each bit, and with bit 4 set on the trailing edge.
- R5: Message kind 0 (address 1, bits [1:0]) is full duplex: the byte received during main byte j goes to receive entry j, and the tail register at address 7 ends equal to the main length at address 0.
- R6: Message kind 2 is receive-only: the data output is held low for the main bytes, every main byte is captured, and the tail ends equal to the main length.
- R7: Message kind 1 is transmit-only: the serial input is ignored, the receive buffer is left untouched and the tail stays zero.
- R8: The prepend count (bits [3:0] of the command) of 0 to 15 bytes is sent ahead of the main length and is never captured, so receive entry 0 always holds the first main byte.
- R9: Bit 0 of address 4 is set when a message ends. The interrupt output equals that bit ANDed with bit 0 of address 5. Writing 0xFF to address 4 clears it, and any other value written there leaves it set.
- R10: Bit 0 of address 6 is high from the command write until the message ends. While it is high, writes to addresses 0 to 3 and to the transmit buffer are dropped.
- R11: A start with zero prepend and zero main length ends at once: the done bit is set, no select line falls and the tail reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for registers and transmit buffer |
| bus_addr_i | input | $clog2(FIFO_DEPTH)+2 | Byte address: region in the top two bits |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for the addressed location |
| irq_o | output | 1 | Masked done interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the target |
| miso_i | input | 1 | Serial data from the target |
| cs_no | output | NUM_CS | Active-low select lines |

## Verification
Messages run under all three message kinds, with and without prepend, at prepend counts from zero to fifteen, in all four clock polarity and phase combinations and at several clock codes. The bench acts as a target that returns a random byte stream, so a capture offset by a prepend byte or a bit slip shows up as a data mismatch. Comparing the data line against the buffer contents separates a wrong sampling edge from a wrong launch order. Counting select-low cycles pins down the divider and the end-of-message edge. Directed cases cover the zero-length start, clock code 7, the mask and clear-all paths, and writes dropped while a message is in progress.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;

  typedef enum logic [1:0] {
    MT_FULL = 2'd0,
    MT_HDW  = 2'd1,
    MT_HDR  = 2'd2,
    MT_RSVD = 2'd3
  } msg_type_e;

  localparam logic [2:0] RA_LEN   = 3'd0;
  localparam logic [2:0] RA_TYPE  = 3'd1;
  localparam logic [2:0] RA_CMD   = 3'd2;
  localparam logic [2:0] RA_CLK   = 3'd3;
  localparam logic [2:0] RA_ISTAT = 3'd4;
  localparam logic [2:0] RA_IMASK = 3'd5;
  localparam logic [2:0] RA_STAT  = 3'd6;
  localparam logic [2:0] RA_TAIL  = 3'd7;

  localparam logic [1:0] REG_REGION = 2'b00;
  localparam logic [1:0] TX_REGION  = 2'b01;
  localparam logic [1:0] RX_REGION  = 2'b10;

  localparam logic [7:0] IRQ_CLR_ALL = 8'hFF;
  localparam int         CMD_GO_BIT  = 7;
  localparam int         MAX_RATE    = 6;

  typedef struct packed {
    msg_type_e  mtype;
    logic [3:0] prep;
    logic [2:0] dev;
    logic [2:0] rate;
    logic       cpol;
    logic       cpha;
  } cfg_t;

endpackage

// File: rtl/spi_msg_regs.sv
module spi_msg_regs
  import spi_msg_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bus_we_i,
  input  logic [$clog2(DEPTH)+1:0]      bus_addr_i,
  input  logic [7:0]                    bus_wdata_i,
  output logic [7:0]                    bus_rdata_o,
  input  logic                          running_i,
  input  logic                          done_i,
  input  logic                          rx_we_i,
  input  logic [$clog2(DEPTH)-1:0]      rx_idx_i,
  input  logic [7:0]                    rx_data_i,
  input  logic [$clog2(DEPTH)-1:0]      tx_idx_i,
  output logic [7:0]                    tx_data_o,
  input  logic [$clog2(DEPTH):0]        tail_i,
  output cfg_t                          cfg_o,
  output logic [$clog2(DEPTH):0]        len_o,
  output logic                          start_o,
  output logic                          busy_o,
  output logic                          pend_o,
  output logic                          mask_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AW    = IDX_W + 2;
  localparam int CW    = IDX_W + 1;

  logic [1:0]       region;
  logic [IDX_W-1:0] ridx;
  logic [2:0]       rsel;
  logic             reg_hit, cfg_we;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];

  logic [CW-1:0] len_q;
  cfg_t          cfg_q;
  logic          start_q, pend_q, mask_q;

  assign region  = bus_addr_i[AW-1 -: 2];
  assign ridx    = bus_addr_i[IDX_W-1:0];
  assign rsel    = bus_addr_i[2:0];
  assign reg_hit = (region == REG_REGION) && (ridx[IDX_W-1:3] == '0);
  assign busy_o  = running_i | start_q;
  assign cfg_we  = bus_we_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= '0;
      cfg_q   <= '0;
      start_q <= 1'b0;
      pend_q  <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      start_q <= cfg_we && reg_hit && (rsel == RA_CMD) && bus_wdata_i[CMD_GO_BIT];
      if (cfg_we && reg_hit) begin
        unique case (rsel)
          RA_LEN:  len_q <= bus_wdata_i[CW-1:0];
          RA_TYPE: cfg_q.mtype <= msg_type_e'(bus_wdata_i[1:0]);
          RA_CMD: begin
            cfg_q.prep <= bus_wdata_i[3:0];
            cfg_q.dev  <= bus_wdata_i[6:4];
          end
          RA_CLK: begin
            cfg_q.rate <= bus_wdata_i[2:0];
            cfg_q.cpol <= bus_wdata_i[3];
            cfg_q.cpha <= bus_wdata_i[4];
          end
          default: ;
        endcase
      end
      if (bus_we_i && reg_hit && rsel == RA_IMASK) mask_q <= bus_wdata_i[0];
      // completion wins over a clear landing on the same edge
      if (done_i) pend_q <= 1'b1;
      else if (bus_we_i && reg_hit && rsel == RA_ISTAT && bus_wdata_i == IRQ_CLR_ALL)
        pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (cfg_we && region == TX_REGION) tx_mem[ridx] <= bus_wdata_i;
    if (rx_we_i) rx_mem[rx_idx_i] <= rx_data_i;
  end

  always_comb begin
    bus_rdata_o = 8'h00;
    unique case (region)
      REG_REGION: if (reg_hit) begin
        unique case (rsel)
          RA_LEN:   bus_rdata_o = 8'(len_q);
          RA_TYPE:  bus_rdata_o = {6'b0, cfg_q.mtype};
          RA_CMD:   bus_rdata_o = {1'b0, cfg_q.dev, cfg_q.prep};
          RA_CLK:   bus_rdata_o = {3'b0, cfg_q.cpha, cfg_q.cpol, cfg_q.rate};
          RA_ISTAT: bus_rdata_o = {7'b0, pend_q};
          RA_IMASK: bus_rdata_o = {7'b0, mask_q};
          RA_STAT:  bus_rdata_o = {7'b0, busy_o};
          RA_TAIL:  bus_rdata_o = 8'(tail_i);
          default:  bus_rdata_o = 8'h00;
        endcase
      end
      TX_REGION: bus_rdata_o = tx_mem[ridx];
      RX_REGION: bus_rdata_o = rx_mem[ridx];
      default:   bus_rdata_o = 8'h00;
    endcase
  end

  assign tx_data_o = tx_mem[tx_idx_i];
  assign cfg_o     = cfg_q;
  assign len_o     = len_q;
  assign start_o   = start_q;
  assign pend_o    = pend_q;
  assign mask_o    = mask_q;

endmodule

// File: rtl/spi_msg_clkdiv.sv
module spi_msg_clkdiv
  import spi_msg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] rate_i,
  output logic       tick_o
);
  localparam int CNT_W = MAX_RATE;

  logic [CNT_W-1:0] cnt_q, lim;
  logic [2:0]       eff;

  assign eff    = (rate_i > 3'(MAX_RATE)) ? 3'(MAX_RATE) : rate_i;
  assign lim    = ~({CNT_W{1'b1}} << eff);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
  import spi_msg_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int NCS   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  msg_type_e                  mtype_i,
  input  logic [3:0]                 prep_i,
  input  logic [2:0]                 dev_i,
  input  logic                       cpol_i,
  input  logic                       cpha_i,
  input  logic [$clog2(DEPTH):0]     len_i,
  input  logic                       tick_i,
  input  logic                       miso_i,
  input  logic [7:0]                 tx_data_i,
  output logic [$clog2(DEPTH)-1:0]   tx_idx_o,
  output logic                       rx_we_o,
  output logic [$clog2(DEPTH)-1:0]   rx_idx_o,
  output logic [7:0]                 rx_data_o,
  output logic [$clog2(DEPTH):0]     tail_o,
  output logic                       running_o,
  output logic                       done_o,
  output logic                       sck_o,
  output logic                       mosi_o,
  output logic [NCS-1:0]             cs_no
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CW    = IDX_W + 1;
  localparam int TW    = CW + 1;

  logic          running_q, lead_q, half_q;
  logic [2:0]    bit_q;
  logic [TW-1:0] byte_q, next_byte, total;
  logic [7:0]    tx_sh, rx_sh;
  logic [CW-1:0] tail_q;
  logic          last_half, last_byte, capture;

  function automatic logic [7:0] launch(input logic [TW-1:0] k, input logic [7:0] d);
    // prepend bytes always go out; receive-only main bytes drive zero
    if (k < TW'(prep_i) || mtype_i != MT_HDR) return d;
    return 8'h00;
  endfunction

  assign total     = TW'(prep_i) + TW'(len_i);
  assign next_byte = byte_q + 1'b1;
  assign last_half = running_q && !lead_q && tick_i && half_q && (bit_q == 3'd7);
  assign last_byte = (byte_q == total - 1'b1);
  assign capture   = (byte_q >= TW'(prep_i)) && (mtype_i != MT_HDW);

  assign tx_idx_o  = start_i ? '0 : next_byte[IDX_W-1:0];
  assign rx_we_o   = last_half && capture;
  assign rx_idx_o  = tail_q[IDX_W-1:0];
  assign rx_data_o = rx_sh;
  assign tail_o    = tail_q;
  assign running_o = running_q;
  assign done_o    = (start_i && total == '0) || (last_half && last_byte);
  assign mosi_o    = running_q & tx_sh[7];
  assign sck_o     = (running_q && !lead_q) ? (cpol_i ^ half_q ^ cpha_i) : cpol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      lead_q    <= 1'b0;
      half_q    <= 1'b0;
      bit_q     <= '0;
      byte_q    <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      tail_q    <= '0;
    end else if (start_i) begin
      running_q <= (total != '0);
      lead_q    <= 1'b1;
      half_q    <= 1'b0;
      bit_q     <= '0;
      byte_q    <= '0;
      tail_q    <= '0;
      tx_sh     <= launch('0, tx_data_i);
    end else if (running_q && tick_i) begin
      if (lead_q) begin
        lead_q <= 1'b0;
      end else if (!half_q) begin
        half_q <= 1'b1;
        rx_sh  <= {rx_sh[6:0], miso_i};
      end else begin
        half_q <= 1'b0;
        if (bit_q == 3'd7) begin
          bit_q <= '0;
          if (capture) tail_q <= tail_q + 1'b1;
          if (last_byte) begin
            running_q <= 1'b0;
          end else begin
            byte_q <= next_byte;
            tx_sh  <= launch(next_byte, tx_data_i);
          end
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_no[i] = ~(running_q && dev_i == 3'(i));
  end

endmodule

// File: rtl/spi_msg_engine.sv
module spi_msg_engine
  import spi_msg_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_CS     = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            bus_we_i,
  input  logic [$clog2(FIFO_DEPTH)+1:0]   bus_addr_i,
  input  logic [7:0]                      bus_wdata_i,
  output logic [7:0]                      bus_rdata_o,
  output logic                            irq_o,
  output logic                            sck_o,
  output logic                            mosi_o,
  input  logic                            miso_i,
  output logic [NUM_CS-1:0]               cs_no
);
  localparam int IDX_W = $clog2(FIFO_DEPTH);
  localparam int CW    = IDX_W + 1;

  cfg_t             cfg;
  logic [CW-1:0]    len_q, tail;
  logic             start, busy, running, done, tick, pend, mask;
  logic             rx_we;
  logic [IDX_W-1:0] rx_idx, tx_idx;
  logic [7:0]       rx_data, tx_data;
  logic [1:0]       mtype_bits;

  assign mtype_bits = cfg.mtype;
  assign irq_o      = pend & mask;

  spi_msg_regs #(.DEPTH(FIFO_DEPTH)) u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .running_i(running), .done_i(done),
    .rx_we_i(rx_we), .rx_idx_i(rx_idx), .rx_data_i(rx_data),
    .tx_idx_i(tx_idx), .tx_data_o(tx_data),
    .tail_i(tail), .cfg_o(cfg), .len_o(len_q),
    .start_o(start), .busy_o(busy), .pend_o(pend), .mask_o(mask)
  );

  spi_msg_clkdiv u_div (
    .clk_i, .rst_ni, .en_i(running), .rate_i(cfg.rate), .tick_o(tick)
  );

  spi_msg_seq #(.DEPTH(FIFO_DEPTH), .NCS(NUM_CS)) u_seq (
    .clk_i, .rst_ni, .start_i(start),
    .mtype_i(cfg.mtype), .prep_i(cfg.prep), .dev_i(cfg.dev),
    .cpol_i(cfg.cpol), .cpha_i(cfg.cpha), .len_i(len_q),
    .tick_i(tick), .miso_i, .tx_data_i(tx_data), .tx_idx_o(tx_idx),
    .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_data_o(rx_data),
    .tail_o(tail), .running_o(running), .done_o(done),
    .sck_o, .mosi_o, .cs_no
  );

endmodule

// File: rtl/spi_msg_checker.sv
module spi_msg_checker #(
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_CS     = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          busy,
  input logic                          running,
  input logic                          pend,
  input logic [1:0]                    mtype_bits,
  input logic [$clog2(FIFO_DEPTH):0]   len_q,
  input logic [$clog2(FIFO_DEPTH):0]   tail,
  input logic                          bus_we_i,
  input logic [$clog2(FIFO_DEPTH)+1:0] bus_addr_i,
  input logic [NUM_CS-1:0]             cs_no
);

  assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  assert_cs_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> &cs_no);

  assert_done_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> pend);

  assert_hdw_tail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && mtype_bits == 2'd1) |-> tail == '0);

  assert_tail_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> tail <= len_q);

  assert_len_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && bus_we_i && bus_addr_i == '0) |=> $stable(len_q));

endmodule

bind spi_msg_engine spi_msg_checker #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS)) u_chk (
  .clk_i, .rst_ni, .busy, .running, .pend, .mtype_bits, .len_q, .tail,
  .bus_we_i, .bus_addr_i, .cs_no
);

// File: tb/sim_spi_msg_engine.sv
module sim_spi_msg_engine;
  localparam int DEPTH = 64;
  localparam int NCS   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sck, mosi;
  logic       miso_r = 1'b0;
  logic [NCS-1:0] cs_n;

  always #5 clk = ~clk;

  spi_msg_engine #(.FIFO_DEPTH(DEPTH), .NUM_CS(NCS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso_r), .cs_no(cs_n)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // target model
  logic [7:0] sl_miso [0:127];
  logic [7:0] sl_mosi [0:127];
  logic [7:0] txm [0:63];
  int  s_idx = 0, m_cnt = 0;
  logic cur_cpol = 0, cur_cpha = 0;
  int  cur_dev = 0;
  int  cs_cnt = 0, bad_cnt = 0;
  wire sel = ~&cs_n;

  task automatic upd_miso();
    if (s_idx >= 0 && s_idx < 1024) miso_r = sl_miso[s_idx/8][7-(s_idx%8)];
    else miso_r = 1'b0;
  endtask

  always @(posedge sel) begin
    s_idx = cur_cpha ? -1 : 0;
    m_cnt = 0;
    upd_miso();
  end

  always @(sck) if (sel) begin
    if (sck == ~(cur_cpol ^ cur_cpha)) begin
      if (m_cnt < 1024) sl_mosi[m_cnt/8][7-(m_cnt%8)] = mosi;
      m_cnt++;
    end else begin
      s_idx++;
      upd_miso();
    end
  end

  always @(negedge clk) begin
    if (cs_n[cur_dev] == 1'b0) cs_cnt++;
    if (((~cs_n) & ~(NCS'(1) << cur_dev)) != '0) bad_cnt++;
  end

  function automatic logic [7:0] exp_mosi(input int k, input int p, input int mt);
    if (k < p || mt != 2) return txm[k];
    return 8'h00;
  endfunction

  function automatic int exp_cs(input int t, input int rate);
    int eff;
    eff = (rate > 6) ? 6 : rate;
    if (t == 0) return 0;
    return (16*t + 1) << eff;
  endfunction

  function automatic string kind_req(input int mt);
    if (mt == 0) return "R5";
    if (mt == 1) return "R7";
    return "R6";
  endfunction

  task automatic run_msg(input int p, input int n, input int mt, input int rate,
                         input bit cpol, input bit cpha, input int dev, input bit poke);
    logic [7:0] d;
    int t;
    string rq;
    t = p + n;
    rq = kind_req(mt);
    for (int k = 0; k < t; k++) begin
      txm[k] = 8'($urandom);
      wr(8'h40 + 8'(k), txm[k]);
    end
    for (int k = 0; k < 128; k++) sl_miso[k] = 8'($urandom);
    wr(8'h00, 8'(n));
    wr(8'h01, 8'(mt));
    wr(8'h03, {3'b0, cpha, cpol, 3'(rate)});
    wr(8'h04, 8'hFF);
    cur_cpol = cpol; cur_cpha = cpha; cur_dev = dev;
    cs_cnt = 0; bad_cnt = 0; m_cnt = 0;
    wr(8'h02, {1'b1, 3'(dev), 4'(p)});
    if (poke) begin
      rd(8'h06, d);
      chk("R10", "busy after start", 32'(d[0]), 32'd1);
      wr(8'h00, 8'h11);
      wr(8'h40, ~txm[0]);
      wr(8'h03, 8'h07);
    end
    do rd(8'h06, d); while (d[0]);
    chk("R3", "cs low cycles", 32'(cs_cnt), 32'(exp_cs(t, rate)));
    chk("R2", "foreign cs low", 32'(bad_cnt), 32'd0);
    chk("R4", "bits shifted", 32'(m_cnt), 32'(8*t));
    for (int k = 0; k < t; k++)
      chk((k < p) ? "R8" : "R4", $sformatf("mosi byte %0d", k), 32'(sl_mosi[k]), 32'(exp_mosi(k, p, mt)));
    rd(8'h07, d);
    chk(rq, "rx tail", 32'(d), (mt == 1) ? 32'd0 : 32'(n));
    if (mt != 1)
      for (int j = 0; j < n; j++) begin
        rd(8'h80 + 8'(j), d);
        chk((p > 0) ? "R8" : rq, $sformatf("rx byte %0d", j), 32'(d), 32'(sl_miso[p+j]));
      end
    rd(8'h04, d);
    chk("R9", "done pending", 32'(d), 32'd1);
    if (poke) begin
      rd(8'h00, d);
      chk("R10", "len kept", 32'(d), 32'(n));
      rd(8'h40, d);
      chk("R10", "tx buffer kept", 32'(d), 32'(txm[0]));
      rd(8'h03, d);
      chk("R10", "clk reg kept", 32'(d), 32'({3'b0, cpha, cpol, 3'(rate)}));
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "cs idle", 32'(cs_n), 32'hFF);
    chk("R1", "sck idle", 32'(sck), 32'd0);
    chk("R1", "mosi idle", 32'(mosi), 32'd0);
    chk("R1", "irq idle", 32'(irq), 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(8'(a), d);
      chk("R1", $sformatf("reg %0d reset", a), 32'(d), 32'd0);
    end

    run_msg(0, 4, 0, 0, 0, 0, 0, 0);   // full duplex, mode 0
    run_msg(3, 5, 2, 1, 1, 1, 5, 0);   // read after prepend, mode 3
    run_msg(0, 6, 1, 2, 0, 1, 7, 0);   // write only, mode 1
    run_msg(15, 8, 2, 0, 1, 0, 2, 0);  // longest prepend, mode 2
    run_msg(2, 3, 0, 0, 0, 0, 1, 0);   // full duplex behind prepend
    run_msg(1, 0, 1, 7, 0, 0, 3, 0);   // code 7 acts as 6

    // R11: empty message
    run_msg(0, 0, 0, 0, 0, 0, 4, 0);

    // R9: mask and clear paths
    #1 chk("R9", "irq masked", 32'(irq), 32'd0);
    wr(8'h04, 8'h01);
    rd(8'h04, d);
    chk("R9", "non clear value kept pending", 32'(d), 32'd1);
    wr(8'h05, 8'h01);
    #1 chk("R9", "irq unmasked", 32'(irq), 32'd1);
    wr(8'h04, 8'hFF);
    #1 chk("R9", "irq after clear", 32'(irq), 32'd0);
    rd(8'h04, d);
    chk("R9", "pending after clear", 32'(d), 32'd0);

    // R10: writes dropped while busy
    run_msg(1, 8, 0, 3, 0, 0, 6, 1);
    #1 chk("R9", "irq on completion", 32'(irq), 32'd1);

    for (int i = 0; i < 16; i++) begin
      int mt, p, n;
      mt = int'($urandom_range(2, 0));
      p  = ($urandom_range(1, 0) == 1) ? int'($urandom_range(15, 0)) : 0;
      n  = int'($urandom_range(20, 1));
      run_msg(p, n, mt, int'($urandom_range(2, 0)), 1'($urandom), 1'($urandom),
              int'($urandom_range(7, 0)), 0);
    end

    summary();
    $finish;
  end

endmodule